// File: doc/BRIEF.md
# Indexed Display-Controller Register Port

This block is the programming interface of a display controller. Software sees three 32-bit word ports. It writes a register number into the index port, then reads or writes that register through the value port. Behind the index sit several groups of registers:

- the display mode: enable, width, height and pixel depth
- a controller ID that software negotiates
- the hardware cursor registers
- a handshake that accepts a command-ring configuration
- a sync register that starts the command processor
- a bank of general scratch words

Every write is range-checked before it is stored. The ring configuration is accepted only when the ring pointers, presented on input ports, form a legal ring. The mode settings, the enable and config-done flags, and a one-cycle start pulse for the command processor go straight out to the rest of the controller. Reads are combinational from the current index and register state. Writes take effect at the clock edge on which `bus_wr` is sampled high.

Top module: `dispctl_regport`

## Requirements
- R1: `bus_addr` selects a word port. Offset 0 is the index port and reads back the last index written. Offset 1 is the value port, which accesses the indexed register. Offset 2 is an auxiliary port that reads 0 and ignores writes. Any other offset reads 0xFFFFFFFF.
- R2: The ID register (index 0) resets to 0x90000002. A write to it is stored only when the value is 0x90000000, 0x90000001 or 0x90000002; any other value leaves it unchanged.
- R3: The width register (index 2) stores a write only when the value is at most 2360. The height register (index 3) stores a write only when the value is at most 1770. Indexes 4 and 5 read 2360 and 1770. The stored values drive `mode_width` and `mode_height`.
- R4: The bits-per-pixel register (index 7) resets to 32 and accepts only the values 8, 16 and 32. The depth register (index 6) reads 24 when bits per pixel is 32, and reads the bits-per-pixel value otherwise.
- R5: The bytes-per-line register (index 12) reads bits per pixel times width, divided by 8.
- R6: The enable register (index 1) stores bit 0 of the written value, drives `mode_enable`, and reads back that bit.
- R7: Writing a nonzero value to config-done (index 20) sets `cfg_done` only when all of these hold; otherwise it clears `cfg_done`. Writing zero clears it.
  - All four ring pointers are multiples of 4.
  - The ring maximum is at most 0x10000.
  - The ring maximum is at least the ring minimum plus 10240.
  - The next and stop pointers lie in [min, max).
- R8: Writing the sync register (index 21) sets the busy flag and raises `cmd_kick` for exactly the next cycle. A pulse on `cmd_idle` clears busy; when both happen in the same cycle, set wins. The busy register (index 22) reads the flag.
- R9: Writing the cursor-on register (index 27) with 1 makes the cursor visible and with 0 hides it. Values 2 and 3 leave the visible bit unchanged. The register reads the visible bit. Cursor id, x and y (indexes 24 to 26) read back the last value written.
- R10: Scratch words occupy indexes 1792 up to 1792+SCRATCH_N-1 and read back what was written. The scratch-size register (index 29) reads SCRATCH_N. Indexes at or beyond the end of the bank read 0, and writes to them are ignored.
- R11: Palette indexes 1024 to 1791 and all other unmapped indexes read 0. Writes to them change no register.
- R12: After reset, `mode_enable`, `cfg_done`, busy and `cmd_kick` are 0, width and height are 0, and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word offset of the accessed port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed port |
| ring_min | input | 32 | Ring lower bound offset |
| ring_max | input | 32 | Ring upper bound offset |
| ring_next | input | 32 | Ring producer offset |
| ring_stop | input | 32 | Ring consumer offset |
| cmd_idle | input | 1 | Command processor has finished and clears busy |
| mode_enable | output | 1 | Display mode enabled |
| cfg_done | output | 1 | Ring configuration accepted |
| mode_width | output | 12 | Accepted width |
| mode_height | output | 11 | Accepted height |
| mode_bpp | output | 6 | Accepted bits per pixel |
| cmd_kick | output | 1 | One-cycle start pulse for the command processor |

## Verification
Random writes to width, height, bits per pixel, ID and cursor-on are biased toward the acceptance limits. Each write is followed by a readback, so the tests separate a value just inside a limit from one just outside and from a wholly random word. The derived registers are re-read after every mode change, which exposes stale or wrongly scaled depth and bytes-per-line values. Ring configurations are presented one rule at a time: one legal set at the exact minimum gap, then sets that each break a single rule. This shows that each rule rejects on its own. Scratch, palette and out-of-range indexes are written and then read back to show where storage begins and ends.

// File: rtl/dispctl_regport.sv
module dispctl_regport #(
  parameter int          SCRATCH_N  = 16,
  parameter int          MAX_W      = 2360,
  parameter int          MAX_H      = 1770,
  parameter logic [31:0] RING_LIMIT = 32'h0001_0000,
  parameter logic [31:0] RING_GAP   = 32'd10240,
  parameter int          ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       ring_min,
  input  logic [31:0]       ring_max,
  input  logic [31:0]       ring_next,
  input  logic [31:0]       ring_stop,
  input  logic              cmd_idle,
  output logic              mode_enable,
  output logic              cfg_done,
  output logic [11:0]       mode_width,
  output logic [10:0]       mode_height,
  output logic [5:0]        mode_bpp,
  output logic              cmd_kick
);
  localparam logic [31:0] IX_ID     = 32'd0;
  localparam logic [31:0] IX_EN     = 32'd1;
  localparam logic [31:0] IX_W      = 32'd2;
  localparam logic [31:0] IX_H      = 32'd3;
  localparam logic [31:0] IX_MAXW   = 32'd4;
  localparam logic [31:0] IX_MAXH   = 32'd5;
  localparam logic [31:0] IX_DEPTH  = 32'd6;
  localparam logic [31:0] IX_BPP    = 32'd7;
  localparam logic [31:0] IX_BPL    = 32'd12;
  localparam logic [31:0] IX_CFG    = 32'd20;
  localparam logic [31:0] IX_SYNC   = 32'd21;
  localparam logic [31:0] IX_BUSY   = 32'd22;
  localparam logic [31:0] IX_CID    = 32'd24;
  localparam logic [31:0] IX_CX     = 32'd25;
  localparam logic [31:0] IX_CY     = 32'd26;
  localparam logic [31:0] IX_CON    = 32'd27;
  localparam logic [31:0] IX_SSIZE  = 32'd29;
  localparam logic [31:0] SCR_BASE  = 32'd1792;
  localparam int          SCR_W     = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
  localparam logic [31:0] ID_BASE   = 32'h9000_0000;

  logic [31:0] index_q, id_q, cur_id_q, cur_x_q, cur_y_q;
  logic        busy_q, cur_vis_q;
  logic [31:0] scratch_q [SCRATCH_N];

  wire val_wr   = bus_wr && (bus_addr == ADDR_W'(1));
  wire [31:0] scr_diff = index_q - SCR_BASE;
  wire in_scr   = scr_diff < 32'(SCRATCH_N);
  wire [SCR_W-1:0] scr_sel = SCR_W'(scr_diff);

  wire [1:0] align_or = ring_min[1:0] | ring_max[1:0] | ring_next[1:0] | ring_stop[1:0];
  wire ring_ok = (align_or == 2'b00) && (ring_max <= RING_LIMIT) &&
                 ({1'b0, ring_max} >= {1'b0, ring_min} + {1'b0, RING_GAP}) &&
                 (ring_next >= ring_min) && (ring_next < ring_max) &&
                 (ring_stop >= ring_min) && (ring_stop < ring_max);

  wire bpp_ok = (bus_wdata == 32'd8) || (bus_wdata == 32'd16) || (bus_wdata == 32'd32);
  wire id_ok  = (bus_wdata == ID_BASE) || (bus_wdata == ID_BASE + 32'd1) ||
                (bus_wdata == ID_BASE + 32'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q     <= '0;
      id_q        <= ID_BASE + 32'd2;
      mode_enable <= 1'b0;
      cfg_done    <= 1'b0;
      mode_width  <= '0;
      mode_height <= '0;
      mode_bpp    <= 6'd32;
      busy_q      <= 1'b0;
      cmd_kick    <= 1'b0;
      cur_id_q    <= '0;
      cur_x_q     <= '0;
      cur_y_q     <= '0;
      cur_vis_q   <= 1'b0;
    end else begin
      cmd_kick <= 1'b0;
      if (cmd_idle) busy_q <= 1'b0;
      if (bus_wr && bus_addr == ADDR_W'(0)) index_q <= bus_wdata;
      if (val_wr) begin
        case (index_q)
          IX_ID:   if (id_ok) id_q <= bus_wdata;
          IX_EN:   mode_enable <= bus_wdata[0];
          IX_W:    if (bus_wdata <= 32'(MAX_W)) mode_width <= bus_wdata[11:0];
          IX_H:    if (bus_wdata <= 32'(MAX_H)) mode_height <= bus_wdata[10:0];
          IX_BPP:  if (bpp_ok) mode_bpp <= bus_wdata[5:0];
          IX_CFG:  cfg_done <= (bus_wdata != 32'd0) && ring_ok;
          IX_SYNC: begin busy_q <= 1'b1; cmd_kick <= 1'b1; end
          IX_CID:  cur_id_q <= bus_wdata;
          IX_CX:   cur_x_q <= bus_wdata;
          IX_CY:   cur_y_q <= bus_wdata;
          IX_CON:  begin
            if (bus_wdata == 32'd1) cur_vis_q <= 1'b1;
            else if (bus_wdata == 32'd0) cur_vis_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < SCRATCH_N; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rst_n) scratch_q[i] <= '0;
      else if (val_wr && in_scr && scr_sel == SCR_W'(i)) scratch_q[i] <= bus_wdata;
    end
  end

  logic [31:0] value_rd;
  wire  [31:0] bpl = (32'(mode_width) * 32'(mode_bpp)) >> 3;

  always_comb begin
    case (index_q)
      IX_ID:    value_rd = id_q;
      IX_EN:    value_rd = 32'(mode_enable);
      IX_W:     value_rd = 32'(mode_width);
      IX_H:     value_rd = 32'(mode_height);
      IX_MAXW:  value_rd = 32'(MAX_W);
      IX_MAXH:  value_rd = 32'(MAX_H);
      IX_DEPTH: value_rd = (mode_bpp == 6'd32) ? 32'd24 : 32'(mode_bpp);
      IX_BPP:   value_rd = 32'(mode_bpp);
      IX_BPL:   value_rd = bpl;
      IX_CFG:   value_rd = 32'(cfg_done);
      IX_BUSY:  value_rd = 32'(busy_q);
      IX_CID:   value_rd = cur_id_q;
      IX_CX:    value_rd = cur_x_q;
      IX_CY:    value_rd = cur_y_q;
      IX_CON:   value_rd = 32'(cur_vis_q);
      IX_SSIZE: value_rd = 32'(SCRATCH_N);
      default:  value_rd = in_scr ? scratch_q[scr_sel] : 32'd0;
    endcase
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(0): bus_rdata = index_q;
      ADDR_W'(1): bus_rdata = value_rd;
      ADDR_W'(2): bus_rdata = 32'd0;
      default:    bus_rdata = 32'hFFFF_FFFF;
    endcase
  end

  p_width_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mode_width) <= 32'(MAX_W));
  p_height_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mode_height) <= 32'(MAX_H));
  p_bpp_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bpp == 6'd8 || mode_bpp == 6'd16 || mode_bpp == 6'd32);
  p_cfg_rise_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(ring_max) <= RING_LIMIT && $past(ring_min[1:0]) == 2'b00);
  p_kick_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_kick |-> busy_q);
  p_cursor_hide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && index_q == IX_CON && bus_wdata == 32'd0) |=> !cur_vis_q);
endmodule

// File: tb/dispctl_regport_tb.sv
module dispctl_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSCR = 16;

  logic clk = 0, rst_n = 0, bus_wr = 0, cmd_idle = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] ring_min = 0, ring_max = 0, ring_next = 0, ring_stop = 0;
  logic mode_enable, cfg_done, cmd_kick;
  logic [11:0] mode_width;
  logic [10:0] mode_height;
  logic [5:0] mode_bpp;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  dispctl_regport #(.SCRATCH_N(NSCR)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // model
  logic [31:0] m_id = 32'h9000_0002, m_w = 0, m_h = 0, m_bpp = 32;
  bit m_vis = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic setreg(logic [31:0] idx, logic [31:0] v);
    wr(0, idx); wr(1, v);
  endtask

  task automatic rdreg(logic [31:0] idx, output logic [31:0] v);
    wr(0, idx); bus_addr = 1; #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] exp_depth(logic [31:0] b);
    return (b == 32) ? 32'd24 : b;
  endfunction

  function automatic logic [31:0] pick(logic [31:0] lim);
    case ($urandom % 4)
      0: return lim - 1 + ($urandom % 3);
      1: return $urandom % 5000;
      2: return $urandom;
      default: return (($urandom % 2) != 0) ? 32'd0 : lim;
    endcase
  endfunction

  task automatic ring(logic [31:0] mn, logic [31:0] mx, logic [31:0] nx, logic [31:0] st);
    ring_min = mn; ring_max = mx; ring_next = nx; ring_stop = st;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 enable", 32'(mode_enable), 0);
    chk("R12 cfg_done", 32'(cfg_done), 0);
    chk("R12 kick", 32'(cmd_kick), 0);
    chk("R12 width", 32'(mode_width), 0);
    bus_addr = 0; #1 chk("R12 index", bus_rdata, 0);
    rdreg(22, v); chk("R12 busy", v, 0);
    rdreg(0, v); chk("R2 reset id", v, 32'h9000_0002);
    rdreg(6, v); chk("R4 reset depth", v, 24);

    // R1 ports
    wr(0, 32'h1234_5678); bus_addr = 0; #1 chk("R1 index readback", bus_rdata, 32'h1234_5678);
    wr(2, 32'hDEAD_BEEF); bus_addr = 2; #1 chk("R1 aux reads 0", bus_rdata, 0);
    bus_addr = 3; #1 chk("R1 offset3", bus_rdata, 32'hFFFF_FFFF);
    bus_addr = 15; #1 chk("R1 offset15", bus_rdata, 32'hFFFF_FFFF);
    rdreg(4, v); chk("R3 max width", v, 2360);
    rdreg(5, v); chk("R3 max height", v, 1770);

    // directed boundaries
    setreg(2, 2360); m_w = 2360; chk("R3 width 2360", 32'(mode_width), 2360);
    setreg(2, 2361); chk("R3 width 2361 dropped", 32'(mode_width), 2360);
    setreg(3, 1770); m_h = 1770; chk("R3 height 1770", 32'(mode_height), 1770);
    setreg(3, 1771); chk("R3 height 1771 dropped", 32'(mode_height), 1770);
    setreg(7, 24); chk("R4 bpp 24 rejected", 32'(mode_bpp), 32);
    setreg(7, 16); m_bpp = 16; rdreg(6, v); chk("R4 depth 16", v, 16);
    rdreg(12, v); chk("R5 bpl", v, (m_w * m_bpp) >> 3);
    setreg(0, 32'h9000_0003); rdreg(0, v); chk("R2 bad id ignored", v, m_id);
    setreg(0, 32'h9000_0000); m_id = 32'h9000_0000; rdreg(0, v); chk("R2 id0", v, m_id);

    // R6 enable
    setreg(1, 32'hFFFF_FFFF); chk("R6 enable set", 32'(mode_enable), 1);
    rdreg(1, v); chk("R6 enable read", v, 1);
    setreg(1, 32'h2); chk("R6 enable bit0 only", 32'(mode_enable), 0);

    // random mode traffic
    for (int it = 0; it < 200; it++) begin
      logic [31:0] d;
      case ($urandom % 5)
        0: begin d = pick(2360); setreg(2, d); if (d <= 2360) m_w = d;
             rdreg(2, v); chk("R3 rand width", v, m_w);
             chk("R3 width port", 32'(mode_width), m_w); end
        1: begin d = pick(1770); setreg(3, d); if (d <= 1770) m_h = d;
             rdreg(3, v); chk("R3 rand height", v, m_h); end
        2: begin
             case ($urandom % 4) 0: d = 8; 1: d = 16; 2: d = 32; default: d = $urandom % 40; endcase
             setreg(7, d); if (d == 8 || d == 16 || d == 32) m_bpp = d;
             rdreg(7, v); chk("R4 rand bpp", v, m_bpp);
             rdreg(6, v); chk("R4 rand depth", v, exp_depth(m_bpp)); end
        3: begin d = 32'h9000_0000 + ($urandom % 5); if (($urandom % 3) == 0) d = $urandom;
             setreg(0, d); if (d >= 32'h9000_0000 && d <= 32'h9000_0002) m_id = d;
             rdreg(0, v); chk("R2 rand id", v, m_id); end
        default: begin d = $urandom % 5;
             setreg(27, d); if (d == 1) m_vis = 1; else if (d == 0) m_vis = 0;
             rdreg(27, v); chk("R9 rand cursor_on", v, 32'(m_vis)); end
      endcase
      rdreg(12, v); chk("R5 rand bpl", v, (m_w * m_bpp) >> 3);
    end

    // R9 cursor regs
    setreg(27, 1); setreg(27, 2); rdreg(27, v); chk("R9 value2 keeps", v, 1);
    setreg(27, 0); setreg(27, 3); rdreg(27, v); chk("R9 value3 keeps", v, 0);
    setreg(25, 32'd640); rdreg(25, v); chk("R9 cursor x", v, 640);

    // R7 config
    ring(16, 16 + 10240, 16, 32);
    setreg(20, 1); chk("R7 valid min gap", 32'(cfg_done), 1);
    setreg(20, 0); chk("R7 zero clears", 32'(cfg_done), 0);
    ring(16, 16 + 10236, 16, 16); setreg(20, 1); chk("R7 gap short", 32'(cfg_done), 0);
    ring(32'h10000 - 10240, 32'h10000, 32'h10000 - 8, 32'h10000 - 10240);
    setreg(20, 1); chk("R7 max at limit", 32'(cfg_done), 1);
    ring(16, 32'h10004, 16, 16); setreg(20, 1); chk("R7 max over limit", 32'(cfg_done), 0);
    ring(16, 16 + 10240, 18, 16); setreg(20, 1); chk("R7 misaligned", 32'(cfg_done), 0);
    ring(16, 16 + 10240, 16 + 10240, 16); setreg(20, 1); chk("R7 next at max", 32'(cfg_done), 0);
    rdreg(20, v); chk("R7 read", v, 0);

    // R8 sync / busy
    setreg(21, 1); chk("R8 kick high", 32'(cmd_kick), 1);
    @(negedge clk); chk("R8 kick one cycle", 32'(cmd_kick), 0);
    rdreg(22, v); chk("R8 busy set", v, 1);
    @(negedge clk); cmd_idle = 1; @(negedge clk); cmd_idle = 0;
    rdreg(22, v); chk("R8 busy cleared", v, 0);

    // R10 scratch
    rdreg(29, v); chk("R10 scratch size", v, NSCR);
    for (int k = 0; k < NSCR; k++) setreg(1792 + k, 32'hA500_0000 + k);
    for (int k = 0; k < NSCR; k += 5) begin
      rdreg(1792 + k, v); chk("R10 scratch read", v, 32'hA500_0000 + k);
    end
    rdreg(1792 + NSCR - 1, v); chk("R10 last scratch", v, 32'hA500_0000 + NSCR - 1);
    setreg(1792 + NSCR, 32'h5555); rdreg(1792 + NSCR, v); chk("R10 beyond bank", v, 0);
    rdreg(1792, v); chk("R10 first intact", v, 32'hA500_0000);

    // R11 palette / unmapped
    setreg(1024, 32'h77); rdreg(1024, v); chk("R11 palette low", v, 0);
    setreg(1791, 32'h77); rdreg(1791, v); chk("R11 palette high", v, 0);
    setreg(40, 32'h77); rdreg(40, v); chk("R11 unmapped", v, 0);
    rdreg(2, v); chk("R11 width untouched", v, m_w);
    rdreg(1792, v); chk("R11 scratch untouched", v, 32'hA500_0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule